// File: doc/BRIEF.md
# Light-Sensor Conversion Sequencer

This block steps an integrating light-measurement channel through its conversions. A 3-bit operating mode picks one of three behaviours: the channel is off, the channel takes one measurement and then switches itself off, or the channel measures continuously. The mode also picks the visible or the infrared photodiode. A 2-bit resolution select sets the result width to 16, 12, 8 or 4 bits. The same select sets the integration length, which is 2^n ticks of the oscillator for a width of n bits.

The analog front end is not modelled. Its charge-balancing modulator appears only as a pulse input, and the block samples that input on each oscillator tick of an integration. At the end of an integration the block copies the saturated pulse count into its data register and raises a one-cycle done pulse for the interrupt logic. In one-shot modes it then returns to power-down and keeps the result. In continuous modes the next integration starts without a gap. The lux range select goes straight through to the front end and has no effect on timing.

Top module: `lsn_conv_seq`

## Requirements
- R1: After reset, data_out is 0, conv_done is low, fe_enable is low and the mode is power-down.
- R2: Mode codes work as follows: 000 is power-down, 001 takes one visible conversion, 010 takes one IR conversion, 101 runs visible conversions continuously and 110 runs IR conversions continuously. fe_enable is high in every mode except power-down. fe_ir_sel is high in the two IR modes.
- R3: The reserved codes 011, 100 and 111 behave as power-down: fe_enable stays low and no conversion completes.
- R4: Resolution codes 00, 01, 10 and 11 select n = 16, 12, 8 and 4. Count the clock edge that accepts the mode write as edge 0. conv_done is then first seen high after the edge that carries the 2^n-th osc_tick.
- R5: The result is the number of edges on which both osc_tick and mod_pulse were high during the integration, saturated at 2^n-1. It is unsigned and right-aligned, and the bits above n read 0. mod_pulse is ignored when osc_tick is low.
- R6: After a one-shot conversion, fe_enable goes low on the same edge that updates the data, and data_out holds the result.
- R7: In the continuous modes, conversions follow each other with no gap, and data_out is overwritten on each completion.
- R8: A mode write aborts any conversion in progress and restarts integration from its first tick. If the write falls on the edge of the final tick, the write wins: no conv_done and no data update.
- R9: fe_range always equals range_sel, and changing it does not alter conversion timing.
- R10: conv_done lasts exactly one cycle and is high in the first cycle that data_out shows the new result.
- R11: res_sel is sampled at the mode write and again at the start of each continuous conversion. A change during an integration takes effect at the next conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Strobe that writes mode_code |
| mode_code | input | 3 | Operating mode code |
| res_sel | input | 2 | Resolution select |
| range_sel | input | 2 | Lux range select, passed to the front end |
| osc_tick | input | 1 | Oscillator tick enable |
| mod_pulse | input | 1 | Modulator pulse, sampled on ticks |
| fe_enable | output | 1 | Front end powered and integrating |
| fe_ir_sel | output | 1 | Selects the IR photodiode |
| fe_range | output | 2 | Range forwarded to the front end |
| data_out | output | DATA_W | Last conversion result |
| conv_done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall on the same edge: a mode write and the final integration tick. The bench starts a continuous 4-bit conversion, counts fifteen ticks into the second integration, and then issues the write so that it lands on the closing tick. It then checks three things: conv_done stays low, data_out still shows the first result, and the next completion arrives a full 16 ticks after the write with a count of only the post-write pulses.

// File: rtl/lsn_seq_pkg.sv
package lsn_seq_pkg;

   localparam int RES_STEP = 4;

   typedef enum logic [2:0] {
      OPM_OFF      = 3'b000,
      OPM_VIS_ONCE = 3'b001,
      OPM_IR_ONCE  = 3'b010,
      OPM_VIS_CONT = 3'b101,
      OPM_IR_CONT  = 3'b110
   } opmode_e;

   typedef struct packed {
      logic run;
      logic ir;
      logic cont;
   } mode_ctl_t;

   // Map a raw code onto a legal mode; reserved codes fall to power-down
   function automatic opmode_e legalize(input logic [2:0] code);
      case (code)
         3'b001:  return OPM_VIS_ONCE;
         3'b010:  return OPM_IR_ONCE;
         3'b101:  return OPM_VIS_CONT;
         3'b110:  return OPM_IR_CONT;
         default: return OPM_OFF;
      endcase
   endfunction

endpackage

// File: rtl/lsn_mode_dec.sv
module lsn_mode_dec
   import lsn_seq_pkg::*;
(
   input  opmode_e   mode,
   output mode_ctl_t ctl
);

   always_comb begin
      ctl = '0;
      case (mode)
         OPM_VIS_ONCE: ctl = '{run: 1'b1, ir: 1'b0, cont: 1'b0};
         OPM_IR_ONCE:  ctl = '{run: 1'b1, ir: 1'b1, cont: 1'b0};
         OPM_VIS_CONT: ctl = '{run: 1'b1, ir: 1'b0, cont: 1'b1};
         OPM_IR_CONT:  ctl = '{run: 1'b1, ir: 1'b1, cont: 1'b1};
         default:      ctl = '0;
      endcase
   end

endmodule

// File: rtl/lsn_res_limit.sv
module lsn_res_limit
   import lsn_seq_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [1:0]   res,
   output logic [W-1:0] lim
);

   localparam int NUM_RES = 4;
   localparam int MIN_W   = RES_STEP * (NUM_RES - 1) + 1;

   generate
      if (W < MIN_W) begin : g_bad_width
         $error("lsn_res_limit: W must leave at least one bit at the coarsest resolution");
      end
   endgenerate

   logic [W-1:0] lim_tab [NUM_RES];

   // Entry g holds the terminal count for a width of W - 4*g bits
   generate
      for (genvar g = 0; g < NUM_RES; g++) begin : g_tab
         assign lim_tab[g] = {W{1'b1}} >> (RES_STEP * g);
      end
   endgenerate

   assign lim = lim_tab[res];

endmodule

// File: rtl/lsn_int_timer.sv
module lsn_int_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         run,
   input  logic         tick,
   input  logic [W-1:0] lim,
   output logic         last
);

   logic [W-1:0] cnt_q;

   assign last = run & tick & (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         cnt_q <= last ? '0 : cnt_q + W'(1);
      end
   end

   a_r4_cnt_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim);

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/lsn_pulse_acc.sv
module lsn_pulse_acc #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         pulse,
   input  logic [W-1:0] lim,
   output logic [W-1:0] val_next
);

   logic [W-1:0] acc_q;

   // Count including the current cycle's pulse, held at the limit
   always_comb begin
      val_next = acc_q;
      if (en && pulse && (acc_q != lim)) begin
         val_next = acc_q + W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_q <= '0;
      end else begin
         acc_q <= val_next;
      end
   end

   a_r5_acc_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q <= lim);

   a_r5_offtick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(acc_q));

endmodule

// File: rtl/lsn_conv_seq.sv
module lsn_conv_seq
   import lsn_seq_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_code,
   input  logic [1:0]        res_sel,
   input  logic [1:0]        range_sel,
   input  logic              osc_tick,
   input  logic              mod_pulse,
   output logic              fe_enable,
   output logic              fe_ir_sel,
   output logic [1:0]        fe_range,
   output logic [DATA_W-1:0] data_out,
   output logic              conv_done
);

   opmode_e           mode_q;
   mode_ctl_t         ctl;
   logic [1:0]        res_q;
   logic [DATA_W-1:0] lim;
   logic [DATA_W-1:0] acc_next;
   logic [DATA_W-1:0] data_q;
   logic              done_q;
   logic              last;
   logic              seq_clr;

   lsn_mode_dec u_dec (
      .mode (mode_q),
      .ctl  (ctl)
   );

   lsn_res_limit #(.W(DATA_W)) u_lim (
      .res (res_q),
      .lim (lim)
   );

   // A write or a completed integration both start the next window afresh
   assign seq_clr = mode_wr | last;

   lsn_int_timer #(.W(DATA_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (seq_clr),
      .run   (ctl.run),
      .tick  (osc_tick),
      .lim   (lim),
      .last  (last)
   );

   lsn_pulse_acc #(.W(DATA_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (seq_clr),
      .en       (ctl.run & osc_tick),
      .pulse    (mod_pulse),
      .lim      (lim),
      .val_next (acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= OPM_OFF;
         res_q  <= '0;
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (mode_wr) begin
            mode_q <= legalize(mode_code);
            res_q  <= res_sel;
         end else if (last) begin
            data_q <= acc_next;
            done_q <= 1'b1;
            res_q  <= res_sel;
            if (!ctl.cont) begin
               mode_q <= OPM_OFF;
            end
         end
      end
   end

   assign fe_enable = ctl.run;
   assign fe_ir_sel = ctl.ir;
   assign fe_range  = range_sel;
   assign data_out  = data_q;
   assign conv_done = done_q;

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> !conv_done);

   a_r8_write_suppresses_done: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr |=> !conv_done);

   a_r6_oneshot_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && $past(ctl.run && !ctl.cont)) |-> !fe_enable);

   a_r7_cont_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_done && $past(ctl.cont)) |-> fe_enable);

   a_r3_reserved_is_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (mode_code == 3'b011 || mode_code == 3'b100 || mode_code == 3'b111))
      |=> !fe_enable);

   a_r10_data_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |-> $stable(data_out));

endmodule

// File: tb/tb_lsn_conv_seq.sv
module tb_lsn_conv_seq;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [2:0]    mode_code = 3'b000;
   logic [1:0]    res_sel = 2'b00;
   logic [1:0]    range_sel = 2'b00;
   logic          osc_tick = 1'b1;
   logic          mod_pulse = 1'b0;
   logic          fe_enable;
   logic          fe_ir_sel;
   logic [1:0]    fe_range;
   logic [DW-1:0] data_out;
   logic          conv_done;

   int n_cmp = 0;
   int n_bad = 0;

   always #10ns clk = ~clk;

   lsn_conv_seq #(.DATA_W(DW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (mode_wr),
      .mode_code (mode_code),
      .res_sel   (res_sel),
      .range_sel (range_sel),
      .osc_tick  (osc_tick),
      .mod_pulse (mod_pulse),
      .fe_enable (fe_enable),
      .fe_ir_sel (fe_ir_sel),
      .fe_range  (fe_range),
      .data_out  (data_out),
      .conv_done (conv_done)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Called at a negedge; the write is taken on the next rising edge (edge 0)
   task automatic wr_mode(input logic [2:0] code);
      mode_wr   = 1'b1;
      mode_code = code;
      mod_pulse = 1'b0;
      osc_tick  = 1'b1;
      @(negedge clk);
      mode_wr   = 1'b0;
   endtask

   // Drives edges 1..maxk; returns the edge after which conv_done was seen
   task automatic wait_done(input int p, input int tdiv, input bit offtick,
                            input int maxk, output int kd);
      kd = -1;
      for (int k = 1; k <= maxk; k++) begin
         osc_tick  = ((k % tdiv) == 0);
         mod_pulse = offtick ? ((k % tdiv) != 0) : (k <= p);
         @(negedge clk);
         if (conv_done) begin
            kd = k;
            break;
         end
      end
      osc_tick  = 1'b1;
      mod_pulse = 1'b0;
   endtask

   task automatic quiet(input string tag, input int cycles, input longint held);
      int seen = 0;
      for (int k = 0; k < cycles; k++) begin
         osc_tick  = 1'b1;
         mod_pulse = 1'b1;
         @(negedge clk);
         if (conv_done || fe_enable) seen++;
      end
      mod_pulse = 1'b0;
      chk({tag, " no activity"}, seen, 0);
      chk({tag, " data held"}, data_out, held);
   endtask

   initial begin : watchdog
      #3800000ns;
      n_bad++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int kd;
      longint last_data;

      repeat (3) @(negedge clk);
      chk("R1 data in reset", data_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 data after reset", data_out, 0);
      chk("R1 done after reset", conv_done, 0);
      chk("R1 fe_enable after reset", fe_enable, 0);

      // One-shot visible, 4-bit, five pulses
      res_sel = 2'b11;
      wr_mode(3'b001);
      chk("R2 visible once enabled", fe_enable, 1);
      chk("R2 visible once channel", fe_ir_sel, 0);
      wait_done(5, 1, 1'b0, 100, kd);
      chk("R4 4-bit length", kd, 16);
      chk("R5 4-bit count", data_out, 5);
      chk("R6 one-shot off", fe_enable, 0);
      @(negedge clk);
      chk("R10 done single cycle", conv_done, 0);
      chk("R6 result held", data_out, 5);

      // Saturation at 4 bits: pulse on every tick
      wr_mode(3'b001);
      wait_done(100, 1, 1'b0, 100, kd);
      chk("R5 4-bit saturates", data_out, 15);

      // One-shot IR, 8-bit
      res_sel = 2'b10;
      wr_mode(3'b010);
      chk("R2 IR once channel", fe_ir_sel, 1);
      wait_done(100, 1, 1'b0, 400, kd);
      chk("R4 8-bit length", kd, 256);
      chk("R5 8-bit count", data_out, 100);

      // 12-bit, full scale, upper bits read 0
      res_sel = 2'b01;
      wr_mode(3'b001);
      wait_done(5000, 1, 1'b0, 5000, kd);
      chk("R4 12-bit length", kd, 4096);
      chk("R5 12-bit saturate, upper bits 0", data_out, 4095);

      // 16-bit
      res_sel = 2'b00;
      wr_mode(3'b001);
      wait_done(40000, 1, 1'b0, 70000, kd);
      chk("R4 16-bit length", kd, 65536);
      chk("R5 16-bit count", data_out, 40000);

      // Tick every other cycle; pulses only off ticks are ignored
      res_sel = 2'b11;
      wr_mode(3'b001);
      wait_done(0, 2, 1'b1, 100, kd);
      chk("R4 gapped ticks length", kd, 32);
      chk("R5 off-tick pulses ignored", data_out, 0);

      // Continuous visible with range change mid-run
      wr_mode(3'b101);
      range_sel = 2'b10;
      chk("R9 range forwarded", fe_range, 2);
      wait_done(3, 1, 1'b0, 100, kd);
      chk("R9 timing unaffected", kd, 16);
      chk("R7 first result", data_out, 3);
      chk("R7 still enabled", fe_enable, 1);
      range_sel = 2'b01;
      wait_done(9, 1, 1'b0, 100, kd);
      chk("R7 back-to-back length", kd, 16);
      chk("R7 data overwritten", data_out, 9);
      chk("R9 range forwarded again", fe_range, 1);

      // Power-down stops the continuous run
      last_data = data_out;
      wr_mode(3'b000);
      quiet("R2 power-down", 40, last_data);

      // Reserved codes
      wr_mode(3'b011);
      quiet("R3 code 011", 40, last_data);
      wr_mode(3'b100);
      quiet("R3 code 100", 40, last_data);
      wr_mode(3'b111);
      quiet("R3 code 111", 40, last_data);

      // Continuous IR with resolution change during the integration
      wr_mode(3'b110);
      chk("R2 IR continuous channel", fe_ir_sel, 1);
      res_sel = 2'b10;
      wait_done(4, 1, 1'b0, 400, kd);
      chk("R11 current conversion keeps 4-bit", kd, 16);
      wait_done(300, 1, 1'b0, 400, kd);
      chk("R11 next conversion uses 8-bit", kd, 256);
      chk("R11 8-bit saturated count", data_out, 255);

      // Abort mid-integration
      wr_mode(3'b001);
      for (int k = 0; k < 50; k++) begin
         mod_pulse = 1'b1;
         @(negedge clk);
      end
      chk("R8 no early done", conv_done, 0);
      wr_mode(3'b001);
      wait_done(30, 1, 1'b0, 400, kd);
      chk("R8 restart length", kd, 256);
      chk("R8 restart count", data_out, 30);

      // Write colliding with the final tick
      res_sel = 2'b11;
      wr_mode(3'b101);
      wait_done(3, 1, 1'b0, 100, kd);
      chk("R8 collision setup", data_out, 3);
      for (int k = 0; k < 15; k++) begin
         mod_pulse = 1'b1;
         @(negedge clk);
      end
      wr_mode(3'b101);
      chk("R8 write wins, no done", conv_done, 0);
      chk("R8 write wins, data kept", data_out, 3);
      wait_done(7, 1, 1'b0, 100, kd);
      chk("R8 post-collision length", kd, 16);
      chk("R8 post-collision count", data_out, 7);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule